// File: doc/BRIEF.md
# Interleaved Decade Sequence Counter

This block is a synchronous 4-bit state machine that walks a fixed ten-step cycle. The values are not in order. It takes one digit from the bottom of the decimal range, then one from the top, and keeps alternating until the two ends meet. Each enabled rising clock edge advances it by one step. A flag output marks the final step, just before the cycle starts over. Other logic can use this flag as a once-per-cycle strobe.

Six of the sixteen 4-bit codes are not part of the cycle. If one of them reaches the register, the next enabled edge moves it to a fixed legal state, so the counter can never lock up. A synchronous active-high reset returns the counter to the cycle start. A load port, intended for test, places any code in the register so that recovery can be exercised.

Top module: `zigzag_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the state becomes 0 at that edge. This holds whatever `ld` and `en` are doing, because reset has the highest priority.
- R2: The state is shown as a plain unsigned binary value on `state`. When `rst` and `ld` are low and `en` is high, each rising edge moves the state one step along 0, 9, 1, 8, 2, 7, 3, 6, 4, 5.
- R3: An enabled edge taken in state 5 leads to state 0, which closes the cycle. `last` is high exactly while `state` equals 5.
- R4: When `rst`, `ld` and `en` are all low, the state keeps its value. This includes the unused codes 10 to 15.
- R5: An enabled edge taken in an unused code leads to a fixed legal state: 10 and 11 go to 0, 12 and 13 go to 1, and 14 and 15 go to 2. The state is therefore at most 9 after one enabled edge.
- R6: When `ld` is high and `rst` is low, the edge writes `ld_val` into the state, whatever the value of `en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Step enable |
| ld | input | 1 | Test load strobe |
| ld_val | input | 4 | Code written on a load |
| state | output | 4 | Current state, binary |
| last | output | 1 | High while state is 5 |

## Verification
Three functions can land on the same clock edge: reset, load and step. The bench raises `rst`, `ld` and `en` together and expects 0 (R1). It then raises `ld` and `en` together from a mid-cycle state and expects the loaded code rather than the successor (R6). The load-then-step pair is also how recovery is provoked. Each of the six unused codes is loaded, held with the enable low, and then stepped once. The result is judged against the mapping computed arithmetically in the bench.

// File: rtl/zigzag_counter.sv
module zigzag_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] state,
  output logic         last
);
  localparam logic [W-1:0] LAST_CODE = W'(5);
  localparam logic [W-1:0] TOP_LEGAL = W'(9);

  logic [W-1:0] q, succ;

  always_comb begin
    case (q)
      W'(0):          succ = W'(9);
      W'(9):          succ = W'(1);
      W'(1):          succ = W'(8);
      W'(8):          succ = W'(2);
      W'(2):          succ = W'(7);
      W'(7):          succ = W'(3);
      W'(3):          succ = W'(6);
      W'(6):          succ = W'(4);
      W'(4):          succ = W'(5);
      W'(5):          succ = W'(0);
      W'(10), W'(11): succ = W'(0);
      W'(12), W'(13): succ = W'(1);
      default:        succ = W'(2);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ld) q <= ld_val;
    else if (en) q <= succ;
  end

  assign state = q;
  assign last  = (q == LAST_CODE);

  AST_STEP_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (!ld && en) |=> (state <= TOP_LEGAL)); // R5
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!ld && en && last) |=> (state == '0)); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!ld && !en) |=> $stable(state)); // R4
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    ld |=> (state == $past(ld_val))); // R6
endmodule

// File: tb/zigzag_counter_tb_top.sv
module zigzag_counter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1, en = 1'b0, ld = 1'b0;
  logic [3:0] ld_val = '0;
  logic [3:0] state;
  logic last;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  zigzag_counter dut_i (.clk(clk), .rst(rst), .en(en), .ld(ld), .ld_val(ld_val),
                        .state(state), .last(last));

  function automatic int expect_next(int s);
    if (s < 5)  return 9 - s;
    if (s == 5) return 0;
    if (s < 10) return 10 - s;
    return (s - 10) / 2;
  endfunction

  task automatic chk(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic tick(logic r, logic e, logic l, logic [3:0] v);
    rst = r; en = e; ld = l; ld_val = v;
    @(posedge clk); #1;
  endtask

  task automatic load(int code);
    tick(1'b0, 1'b0, 1'b1, 4'(code));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog: got=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int ref_seq [10] = '{0, 9, 1, 8, 2, 7, 3, 6, 4, 5};
    tick(1'b1, 1'b0, 1'b0, 4'd0);
    tick(1'b1, 1'b0, 1'b0, 4'd0);
    chk("R1 reset state", int'(state), 0);
    chk("R3 last after reset", int'(last), 0);

    // R2 R3: two full laps against the reference list
    for (int i = 1; i <= 20; i++) begin
      tick(1'b0, 1'b1, 1'b0, 4'd0);
      chk("R2 sequence", int'(state), ref_seq[i % 10]);
      chk("R3 last flag", int'(last), (ref_seq[i % 10] == 5) ? 1 : 0);
    end

    // R4: hold in a legal state
    load(8);
    for (int k = 0; k < 3; k++) begin
      tick(1'b0, 1'b0, 1'b0, 4'd0);
      chk("R4 hold legal", int'(state), 8);
    end

    // R2 R6: exhaustive single-step sweep over legal codes
    for (int c = 0; c < 10; c++) begin
      load(c);
      chk("R6 load legal", int'(state), c);
      tick(1'b0, 1'b1, 1'b0, 4'd0);
      chk("R2 step", int'(state), expect_next(c));
    end

    // R4 R5 R6: unused codes
    for (int c = 10; c < 16; c++) begin
      load(c);
      chk("R6 load unused", int'(state), c);
      tick(1'b0, 1'b0, 1'b0, 4'd0);
      tick(1'b0, 1'b0, 1'b0, 4'd0);
      chk("R4 hold unused", int'(state), c);
      chk("R3 last unused", int'(last), 0);
      tick(1'b0, 1'b1, 1'b0, 4'd0);
      chk("R5 recover", int'(state), (c - 10) / 2);
    end

    // same-cycle collisions
    load(7);
    tick(1'b1, 1'b1, 1'b1, 4'd13);
    chk("R1 reset beats load and enable", int'(state), 0);
    load(3);
    tick(1'b0, 1'b1, 1'b1, 4'd14);
    chk("R6 load beats enable", int'(state), 14);
    tick(1'b0, 1'b1, 1'b0, 4'd0);
    chk("R5 recover after collision", int'(state), 2);

    // R4 R2: gapped enable pattern
    tick(1'b1, 1'b0, 1'b0, 4'd0);
    for (int i = 1; i <= 10; i++) begin
      tick(1'b0, 1'b1, 1'b0, 4'd0);
      tick(1'b0, 1'b0, 1'b0, 4'd0);
      chk("R4 gapped hold", int'(state), ref_seq[i % 10]);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule